// File: doc/BRIEF.md
# Clock Divisor Search Engine

This block picks a clock setting for a downstream divider stage. Given a target frequency, up to four candidate source frequencies (unsigned integers in any common unit) and the number of sources that are actually wired, it tries every setting the stage offers. A setting is a source index, a power-of-two prescale exponent N in 0..3 and a linear ratio M in 0..31. The frequency that setting produces is `(source >> N) / (M + 1)`, with the division truncated.

The block keeps the setting whose frequency comes closest to the target from below. It never accepts a setting that overshoots the target. When no usable setting exists it raises a fail flag. A controller pulses `start` and waits for `done`, then reads the chosen source, N, M and the achieved frequency. Each candidate is divided by a shared multi-cycle restoring divider, so a search over all four sources takes several thousand cycles.

Top module: `clkdiv_search`

## Requirements
- R1: On success, `out_freq` equals `(S >> sel_n) / (sel_m + 1)` with truncation, where S is the captured frequency of source `sel_src`.
- R2: On success, `out_freq` is nonzero and never above the target. No visited setting lies closer to the target from below.
- R3: When several settings give the same best frequency, the one reported is the first in sweep order. The sweep runs sources from lowest index, then N from 0 to 3, then M from 0 to 31 innermost.
- R4: Only source indices below `src_count` are visited. A count above four visits all four sources.
- R5: The result is a failure when no visited setting yields a frequency in the range 1 to target. This covers a zero target and a zero `src_count`. A failure asserts `fail` and drives `sel_src`, `sel_n`, `sel_m` and `out_freq` to zero.
- R6: A source whose frequency is zero contributes no candidate and never blocks a later source from being chosen.
- R7: `start` is accepted only while `busy` is low. The target, source frequencies and count are captured at the accepted start. A later `start` pulse or input change during a search has no effect on its result.
- R8: `busy` rises on the cycle after an accepted start. `done` is a single-cycle pulse that marks valid results and occurs while `busy` is still high. The result outputs hold their values until the next `done`.
- R9: After reset, `busy`, `done`, `fail`, `sel_src`, `sel_n`, `sel_m` and `out_freq` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request a search; ignored while busy |
| target_freq | input | FREQ_W | Desired frequency |
| src_freqs | input | NSRC*FREQ_W | Source frequencies; source i occupies bits [i*FREQ_W +: FREQ_W] |
| src_count | input | clog2(NSRC+1) | Number of valid sources |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse: results valid |
| fail | output | 1 | No acceptable setting found |
| sel_src | output | max(1,clog2(NSRC)) | Chosen source index |
| sel_n | output | 2 | Chosen power-of-two exponent |
| sel_m | output | 5 | Chosen linear ratio minus one |
| out_freq | output | FREQ_W | Frequency achieved by the chosen setting |

## Verification
The assertions rely on each search being launched by a one-cycle `start` while the block is idle. They also rely on the checker capturing the same target, count and source values that the block captures at that cycle. Nothing is assumed about inputs once a search is running. The bench drives `start` for a single cycle at a falling edge. It changes the inputs mid-search only in the scenario that checks they are ignored. Frequencies stay within the FREQ_W width chosen for the bench.

// File: rtl/clkdiv_pkg.sv
// Package: shared constants and sequencer state encoding for the divisor search.
// Assumes the ratio field widths are fixed by the clock stage: N is 2 bits, M is 5 bits.
package clkdiv_pkg;
    localparam int N_W  = 2;
    localparam int M_W  = 5;
    localparam int DV_W = M_W + 1;  // divisor M+1 reaches 32
    localparam logic [N_W-1:0] N_LAST = '1;
    localparam logic [M_W-1:0] M_LAST = '1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIVGO,
        ST_DIVWAIT,
        ST_DECIDE,
        ST_RECALC_GO,
        ST_RECALC_WAIT,
        ST_REPORT
    } seq_state_e;
endpackage

// File: rtl/cds_divider.sv
// Restoring shift-subtract divider with a fixed latency of W cycles after start.
// Assumes divisor is nonzero and start is raised only when no division is running.
// done pulses one cycle with the truncated quotient on `quotient`.
module cds_divider #(
    parameter int W    = 32,
    parameter int DV_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [W-1:0]    dividend,
    input  logic [DV_W-1:0] divisor,
    output logic            done,
    output logic [W-1:0]    quotient
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]    quo_q;
    logic [DV_W:0]   rem_q;
    logic [DV_W-1:0] dsr_q;
    logic [CW-1:0]   cnt_q;
    logic            run_q;
    logic            done_q;

    logic [DV_W:0]   shifted;
    logic [DV_W:0]   rem_nx;
    logic            q_bit;

    // One restoring step: bring in the next dividend bit, subtract if it fits.
    always_comb begin
        shifted = {rem_q[DV_W-1:0], quo_q[W-1]};
        q_bit   = (shifted >= {1'b0, dsr_q});
        rem_nx  = q_bit ? (shifted - {1'b0, dsr_q}) : shifted;
    end

    // Iteration registers: load on start, step while running, flag the last step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quo_q  <= '0;
            rem_q  <= '0;
            dsr_q  <= '0;
            cnt_q  <= '0;
            run_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                quo_q <= dividend;
                rem_q <= '0;
                dsr_q <= divisor;
                cnt_q <= CW'(W);
                run_q <= 1'b1;
            end else if (run_q) begin
                quo_q <= {quo_q[W-2:0], q_bit};
                rem_q <= rem_nx;
                cnt_q <= cnt_q - CW'(1);
                if (cnt_q == CW'(1)) begin
                    run_q  <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign done     = done_q;
    assign quotient = quo_q;
endmodule

// File: rtl/cds_best_track.sv
// Best-candidate tracker: holds the smallest non-negative (target - candidate) seen.
// Assumes clear comes before the first eval of a search. A candidate replaces the
// held one only when strictly closer, so the earliest of equal candidates is kept.
module cds_best_track #(
    parameter int W     = 32,
    parameter int SRC_W = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear,
    input  logic [W-1:0]               target,
    input  logic                       eval,
    input  logic [W-1:0]               cand,
    input  logic [SRC_W-1:0]           cand_src,
    input  logic [clkdiv_pkg::N_W-1:0] cand_n,
    input  logic [clkdiv_pkg::M_W-1:0] cand_m,
    output logic [SRC_W-1:0]           best_src,
    output logic [clkdiv_pkg::N_W-1:0] best_n,
    output logic [clkdiv_pkg::M_W-1:0] best_m,
    output logic                       found
);
    logic [W-1:0] tgt_q;
    logic [W-1:0] diff_q;
    logic         better;

    // Acceptance rule: no overshoot and strictly smaller distance.
    always_comb begin
        better = (cand <= tgt_q) && ((tgt_q - cand) < diff_q);
    end

    // Best-so-far registers: seeded with the target distance, updated on accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q    <= '0;
            diff_q   <= '0;
            best_src <= '0;
            best_n   <= '0;
            best_m   <= '0;
        end else if (clear) begin
            tgt_q    <= target;
            diff_q   <= target;
            best_src <= '0;
            best_n   <= '0;
            best_m   <= '0;
        end else if (eval && better) begin
            diff_q   <= tgt_q - cand;
            best_src <= cand_src;
            best_n   <= cand_n;
            best_m   <= cand_m;
        end
    end

    assign found = (diff_q != tgt_q);
endmodule

// File: rtl/cds_sequencer.sv
// Sweep sequencer: walks source (outer), N, then M (inner), starting one division
// per candidate, then recomputes the winner's frequency and reports.
// Assumes the divider answers each start with exactly one done pulse.
module cds_sequencer #(
    parameter int NSRC  = 4,
    parameter int SRC_W = 2,
    parameter int CNT_W = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [CNT_W-1:0]           src_count,
    input  logic                       div_done,
    input  logic                       found,
    output logic                       busy,
    output logic                       done,
    output logic                       clear,
    output logic                       div_start,
    output logic                       recalc,
    output logic                       eval,
    output logic                       finish_ok,
    output logic                       finish_fail,
    output logic [SRC_W-1:0]           idx_src,
    output logic [clkdiv_pkg::N_W-1:0] idx_n,
    output logic [clkdiv_pkg::M_W-1:0] idx_m
);
    import clkdiv_pkg::*;

    seq_state_e       state_q;
    seq_state_e       state_nx;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] eff_cnt;
    logic             last_cand;

    // Clamp the requested source count to the number of source inputs.
    always_comb begin
        eff_cnt = (src_count > CNT_W'(NSRC)) ? CNT_W'(NSRC) : src_count;
    end

    // Last point of the sweep: final M, final N, final valid source.
    always_comb begin
        last_cand = (idx_m == M_LAST) && (idx_n == N_LAST) &&
                    ((CNT_W'(idx_src) + CNT_W'(1)) == cnt_q);
    end

    // Control strobes decoded from the current state.
    always_comb begin
        clear       = (state_q == ST_IDLE) && start;
        div_start   = (state_q == ST_DIVGO) || (state_q == ST_RECALC_GO);
        recalc      = (state_q == ST_RECALC_GO) || (state_q == ST_RECALC_WAIT);
        eval        = (state_q == ST_DIVWAIT) && div_done;
        finish_ok   = (state_q == ST_RECALC_WAIT) && div_done;
        finish_fail = (clear && (eff_cnt == '0)) ||
                      ((state_q == ST_DECIDE) && !found);
        busy        = (state_q != ST_IDLE);
        done        = (state_q == ST_REPORT);
    end

    // Next-state selection for the sweep, decision and recompute phases.
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:        if (start) state_nx = (eff_cnt == '0) ? ST_REPORT : ST_DIVGO;
            ST_DIVGO:       state_nx = ST_DIVWAIT;
            ST_DIVWAIT:     if (div_done) state_nx = last_cand ? ST_DECIDE : ST_DIVGO;
            ST_DECIDE:      state_nx = found ? ST_RECALC_GO : ST_REPORT;
            ST_RECALC_GO:   state_nx = ST_RECALC_WAIT;
            ST_RECALC_WAIT: if (div_done) state_nx = ST_REPORT;
            ST_REPORT:      state_nx = ST_IDLE;
            default:        state_nx = ST_IDLE;
        endcase
    end

    // State register and captured source count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_nx;
            if (clear) cnt_q <= eff_cnt;
        end
    end

    // Sweep indices: reset at start, advance M first, then N, then source.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            idx_src <= '0;
            idx_n   <= '0;
            idx_m   <= '0;
        end else if (eval) begin
            if (idx_m == M_LAST) begin
                idx_m <= '0;
                if (idx_n == N_LAST) begin
                    idx_n   <= '0;
                    idx_src <= idx_src + SRC_W'(1);
                end else begin
                    idx_n <= idx_n + N_W'(1);
                end
            end else begin
                idx_m <= idx_m + M_W'(1);
            end
        end
    end
endmodule

// File: rtl/clkdiv_search.sv
// Top of the divisor search: captures inputs at start, feeds the shared divider
// from the sweep indices (or the winner during recompute), and registers results.
// Assumes src_freqs packs source i at bits [i*FREQ_W +: FREQ_W].
module clkdiv_search #(
    parameter int NSRC   = 4,
    parameter int FREQ_W = 32,
    localparam int SRC_W = (NSRC > 1) ? $clog2(NSRC) : 1,
    localparam int CNT_W = $clog2(NSRC + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [FREQ_W-1:0]      target_freq,
    input  logic [NSRC*FREQ_W-1:0] src_freqs,
    input  logic [CNT_W-1:0]       src_count,
    output logic                   busy,
    output logic                   done,
    output logic                   fail,
    output logic [SRC_W-1:0]       sel_src,
    output logic [1:0]             sel_n,
    output logic [4:0]             sel_m,
    output logic [FREQ_W-1:0]      out_freq
);
    import clkdiv_pkg::*;

    logic [FREQ_W-1:0] freq_q [NSRC];

    logic              clear, div_start, recalc, eval, finish_ok, finish_fail;
    logic              div_done, found;
    logic [SRC_W-1:0]  idx_src, best_src, cur_src;
    logic [N_W-1:0]    idx_n, best_n, cur_n;
    logic [M_W-1:0]    idx_m, best_m, cur_m;
    logic [FREQ_W-1:0] dividend, quotient;
    logic [DV_W-1:0]   divisor;

    // Per-source capture registers, loaded on an accepted start.
    for (genvar gi = 0; gi < NSRC; gi++) begin : g_cap
        always_ff @(posedge clk) begin
            if (!rst_n)     freq_q[gi] <= '0;
            else if (clear) freq_q[gi] <= src_freqs[gi*FREQ_W +: FREQ_W];
        end
    end

    // Divider operands: sweep point, or the winning point during recompute.
    always_comb begin
        cur_src  = recalc ? best_src : idx_src;
        cur_n    = recalc ? best_n   : idx_n;
        cur_m    = recalc ? best_m   : idx_m;
        dividend = freq_q[cur_src] >> cur_n;
        divisor  = {1'b0, cur_m} + DV_W'(1);
    end

    cds_sequencer #(.NSRC(NSRC), .SRC_W(SRC_W), .CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .src_count(src_count),
        .div_done(div_done), .found(found), .busy(busy), .done(done),
        .clear(clear), .div_start(div_start), .recalc(recalc), .eval(eval),
        .finish_ok(finish_ok), .finish_fail(finish_fail),
        .idx_src(idx_src), .idx_n(idx_n), .idx_m(idx_m)
    );

    cds_divider #(.W(FREQ_W), .DV_W(DV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .start(div_start), .dividend(dividend),
        .divisor(divisor), .done(div_done), .quotient(quotient)
    );

    cds_best_track #(.W(FREQ_W), .SRC_W(SRC_W)) u_best (
        .clk(clk), .rst_n(rst_n), .clear(clear), .target(target_freq),
        .eval(eval), .cand(quotient), .cand_src(idx_src), .cand_n(idx_n),
        .cand_m(idx_m), .best_src(best_src), .best_n(best_n),
        .best_m(best_m), .found(found)
    );

    // Result registers: winner on success, all-zero with fail on failure.
    always_ff @(posedge clk) begin
        if (!rst_n || finish_fail) begin
            fail     <= finish_fail && rst_n;
            sel_src  <= '0;
            sel_n    <= '0;
            sel_m    <= '0;
            out_freq <= '0;
        end else if (finish_ok) begin
            fail     <= 1'b0;
            sel_src  <= best_src;
            sel_n    <= best_n;
            sel_m    <= best_m;
            out_freq <= quotient;
        end
    end
endmodule

// File: rtl/cds_checker.sv
// Checker for clkdiv_search: mirrors the inputs captured at each accepted start
// and relates the reported result to them. Bound to every clkdiv_search instance.
module cds_checker #(
    parameter int NSRC   = 4,
    parameter int FREQ_W = 32,
    localparam int SRC_W = (NSRC > 1) ? $clog2(NSRC) : 1,
    localparam int CNT_W = $clog2(NSRC + 1)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   start,
    input logic [FREQ_W-1:0]      target_freq,
    input logic [NSRC*FREQ_W-1:0] src_freqs,
    input logic [CNT_W-1:0]       src_count,
    input logic                   busy,
    input logic                   done,
    input logic                   fail,
    input logic [SRC_W-1:0]       sel_src,
    input logic [1:0]             sel_n,
    input logic [4:0]             sel_m,
    input logic [FREQ_W-1:0]      out_freq
);
    logic [FREQ_W-1:0]      tgt_seen;
    logic [CNT_W-1:0]       cnt_seen;
    logic [NSRC*FREQ_W-1:0] frq_seen;
    logic [FREQ_W-1:0]      chosen;

    // Shadow copy of the inputs at each start accepted while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_seen <= '0;
            cnt_seen <= '0;
            frq_seen <= '0;
        end else if (start && !busy) begin
            tgt_seen <= target_freq;
            cnt_seen <= src_count;
            frq_seen <= src_freqs;
        end
    end

    assign chosen = frq_seen[sel_src*FREQ_W +: FREQ_W];

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r8_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    a_r8_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
    a_r8_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(out_freq) && $stable(fail) && $stable(sel_src) &&
                   $stable(sel_n) && $stable(sel_m)));
    a_r2_no_overshoot: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fail) |-> (out_freq <= tgt_seen && out_freq != '0));
    a_r4_src_range: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fail) |-> (CNT_W'(sel_src) < cnt_seen));
    a_r5_fail_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fail) |-> (out_freq == '0 && sel_src == '0 && sel_n == '0 && sel_m == '0));
    a_r1_recomputed: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fail) |-> (out_freq == ((chosen >> sel_n) / (FREQ_W'(sel_m) + FREQ_W'(1)))));
endmodule

bind clkdiv_search cds_checker #(.NSRC(NSRC), .FREQ_W(FREQ_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .target_freq(target_freq),
    .src_freqs(src_freqs), .src_count(src_count), .busy(busy), .done(done),
    .fail(fail), .sel_src(sel_src), .sel_n(sel_n), .sel_m(sel_m),
    .out_freq(out_freq)
);

// File: tb/sim_clkdiv_search.sv
// Directed bench for clkdiv_search: one task per scenario, each comparing the
// outputs against a sweep model written from the requirements and hand values.
module sim_clkdiv_search;
    localparam int NSRC = 4;
    localparam int W    = 24;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            start;
    logic [W-1:0]    target_freq;
    logic [NSRC*W-1:0] src_freqs;
    logic [2:0]      src_count;
    logic            busy, done, fail;
    logic [1:0]      sel_src;
    logic [1:0]      sel_n;
    logic [4:0]      sel_m;
    logic [W-1:0]    out_freq;

    int vectors = 0;
    int errors  = 0;

    // Model results.
    logic [1:0]   m_src;
    logic [1:0]   m_n;
    logic [4:0]   m_m;
    logic [W-1:0] m_freq;
    logic         m_fail;

    always #5 clk = ~clk;

    clkdiv_search #(.NSRC(NSRC), .FREQ_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .target_freq(target_freq),
        .src_freqs(src_freqs), .src_count(src_count), .busy(busy), .done(done),
        .fail(fail), .sel_src(sel_src), .sel_n(sel_n), .sel_m(sel_m),
        .out_freq(out_freq)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    endtask

    // Reference sweep: sources outer, N, M inner; strictly-closer-from-below wins.
    task automatic model(input logic [W-1:0] tgt, input logic [NSRC*W-1:0] fs,
                         input int cnt);
        logic [W-1:0] best;
        int lim;
        lim    = (cnt > NSRC) ? NSRC : cnt;
        best   = tgt;
        m_src  = '0; m_n = '0; m_m = '0;
        for (int s = 0; s < lim; s++)
            for (int n = 0; n < 4; n++)
                for (int m = 0; m < 32; m++) begin
                    logic [W-1:0] c;
                    c = (fs[s*W +: W] >> n) / W'(m + 1);
                    if (c <= tgt && (tgt - c) < best) begin
                        best  = tgt - c;
                        m_src = 2'(s); m_n = 2'(n); m_m = 5'(m);
                    end
                end
        m_fail = (best == tgt);
        m_freq = m_fail ? '0 : (fs[m_src*W +: W] >> m_n) / W'(m_m + 1);
        if (m_fail) begin m_src = '0; m_n = '0; m_m = '0; end
    endtask

    // Launch one search and wait for done; checks busy rise and done width (R8).
    task automatic run(input logic [W-1:0] tgt, input logic [W-1:0] f0,
                       input logic [W-1:0] f1, input logic [W-1:0] f2,
                       input logic [W-1:0] f3, input logic [2:0] cnt);
        @(negedge clk);
        target_freq = tgt;
        src_freqs   = {f3, f2, f1, f0};
        src_count   = cnt;
        start       = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R8", "busy after start", 32'(busy), 32'd1);
        while (!done) @(negedge clk);
    endtask

    task automatic compare_model(input string req);
        check(req, "fail", 32'(fail), 32'(m_fail));
        check(req, "sel_src", 32'(sel_src), 32'(m_src));
        check(req, "sel_n", 32'(sel_n), 32'(m_n));
        check(req, "sel_m", 32'(sel_m), 32'(m_m));
        check(req, "out_freq", 32'(out_freq), 32'(m_freq));
        @(negedge clk);
        check("R8", "done one cycle", 32'(done), 32'd0);
        check("R8", "result held", 32'(out_freq), 32'(m_freq));
    endtask

    task automatic t_reset();
        check("R9", "busy", 32'(busy), 0);
        check("R9", "done", 32'(done), 0);
        check("R9", "fail", 32'(fail), 0);
        check("R9", "sel", 32'({sel_src, sel_n, sel_m}), 0);
        check("R9", "out_freq", 32'(out_freq), 0);
    endtask

    task automatic t_exact();
        run(100, 1200, 0, 0, 0, 1);
        model(100, {24'd0, 24'd0, 24'd0, 24'd1200}, 1);
        check("R1", "exact freq", 32'(out_freq), 100);
        compare_model("R1");
    endtask

    task automatic t_tie_ratio();
        run(8, 64, 0, 0, 0, 1);
        check("R3", "tie keeps n=0", 32'(sel_n), 0);
        check("R3", "tie keeps m=7", 32'(sel_m), 7);
        model(8, {24'd0, 24'd0, 24'd0, 24'd64}, 1);
        compare_model("R3");
    endtask

    task automatic t_tie_source();
        run(50, 900, 900, 0, 0, 2);
        check("R3", "tie keeps src0", 32'(sel_src), 0);
        model(50, {24'd0, 24'd0, 24'd900, 24'd900}, 2);
        compare_model("R3");
    endtask

    task automatic t_count_limit();
        run(777, 1000, 777, 0, 0, 1);
        check("R4", "src1 excluded", 32'(out_freq), 500);
        model(777, {24'd0, 24'd0, 24'd777, 24'd1000}, 1);
        compare_model("R4");
        run(777, 1000, 777, 0, 0, 2);
        check("R4", "src1 included", 32'(sel_src), 1);
        model(777, {24'd0, 24'd0, 24'd777, 24'd1000}, 2);
        compare_model("R4");
    endtask

    task automatic t_count_over();
        run(4321, 1000, 2000, 3000, 4321, 7);
        check("R4", "count clamp reaches src3", 32'(sel_src), 3);
        model(4321, {24'd4321, 24'd3000, 24'd2000, 24'd1000}, 7);
        compare_model("R4");
    endtask

    task automatic t_fail_cases();
        run(2, 1000, 0, 0, 0, 1);
        check("R5", "all above target", 32'(fail), 1);
        model(2, {24'd0, 24'd0, 24'd0, 24'd1000}, 1);
        compare_model("R5");
        run(0, 500, 0, 0, 0, 1);
        check("R5", "zero target", 32'(fail), 1);
        model(0, {24'd0, 24'd0, 24'd0, 24'd500}, 1);
        compare_model("R5");
        run(100, 1200, 0, 0, 0, 0);
        check("R5", "zero count", 32'(fail), 1);
        model(100, {24'd0, 24'd0, 24'd0, 24'd1200}, 0);
        compare_model("R5");
    endtask

    task automatic t_zero_source();
        run(500, 0, 0, 0, 0, 4);
        check("R6", "all-zero sources fail", 32'(fail), 1);
        model(500, '0, 4);
        compare_model("R6");
        run(100, 0, 300, 0, 0, 2);
        check("R6", "later source chosen", 32'(sel_src), 1);
        check("R6", "later source m", 32'(sel_m), 2);
        model(100, {24'd0, 24'd0, 24'd300, 24'd0}, 2);
        compare_model("R6");
    endtask

    task automatic t_ignore_busy();
        @(negedge clk);
        target_freq = 100;
        src_freqs   = {24'd0, 24'd0, 24'd0, 24'd1200};
        src_count   = 1;
        start       = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        target_freq = 7;
        src_freqs   = {24'd5, 24'd5, 24'd5, 24'd999};
        src_count   = 4;
        start       = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        check("R7", "first search kept", 32'(out_freq), 100);
        model(100, {24'd0, 24'd0, 24'd0, 24'd1200}, 1);
        compare_model("R7");
        check("R7", "no restart after done", 32'(busy), 0);
    endtask

    task automatic t_mixed();
        run(33333, 12345, 50000, 777777, 3000000, 4);
        check("R2", "not above target", 32'(out_freq <= 33333), 1);
        model(33333, {24'd3000000, 24'd777777, 24'd50000, 24'd12345}, 4);
        compare_model("R2");
        run(999, 7919, 65535, 0, 0, 2);
        model(999, {24'd0, 24'd0, 24'd65535, 24'd7919}, 2);
        compare_model("R2");
    endtask

    task automatic t_large();
        run(24'hFFFFFF, 24'hFFFFFF, 0, 0, 0, 1);
        check("R1", "full-scale n", 32'(sel_n), 0);
        check("R1", "full-scale m", 32'(sel_m), 0);
        model(24'hFFFFFF, {24'd0, 24'd0, 24'd0, 24'hFFFFFF}, 1);
        compare_model("R1");
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL R8 watchdog: actual timeout expected done");
        summary();
        $finish;
    end

    initial begin
        rst_n       = 1'b0;
        start       = 1'b0;
        target_freq = '0;
        src_freqs   = '0;
        src_count   = '0;
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_exact();
        t_tie_ratio();
        t_tie_source();
        t_count_limit();
        t_count_over();
        t_fail_cases();
        t_zero_source();
        t_ignore_busy();
        t_mixed();
        t_large();
        summary();
        $finish;
    end
endmodule